// File: doc/BRIEF.md
# Configuration Stream Relocation Filter

This block sits in a 32-bit configuration word stream, between the reader that fetches a stored partial configuration image and the port that loads it into the device. It lets one image, built for one reconfigurable region, be loaded into any other region that has the same resources, the same area and the same relative placement of its interface points. Each region covers a whole clock-region row. The filter follows the packet headers in the stream and finds the payload words written to the frame-address register. It moves the row and major-column fields of those words by signed offsets, and in the opposite-half case it inverts the top/bottom bit. When the target lies on the other half of the device, every frame written to the frame-data register is also sent through a mirror unit. That unit reverses the word order and the bit order of the frame and leaves the middle word alone. All other frame data is copied unchanged, because the routing bits inside identical logic columns do not depend on position.

Relocation settings (enable, row offset, major offset, flip-half) are loaded through a small load strobe while no stream is in progress. A multiple-frame-write command cannot be split by this filter when the halves are swapped, so it is flagged. The sticky error output also catches a translated address that falls outside the device limits.

Top module: `cfgreloc_filter`

## Requirements
- R1: With the enable setting clear, every input word appears on the output unchanged in the same cycle it is offered (m_valid follows s_valid, s_ready follows m_ready). Flip and offsets have no effect and the error flag stays clear.
- R2: The filter decodes packet headers. A type-1 header has bits [31:29]=001, a type-2 header has bits [31:29]=010, and the opcode is in bits [28:27] with 10 meaning write. A type-1 header selects a register with bits [17:13] and gives a payload count in bits [10:0]. A type-2 header gives a count in bits [26:0] for the register selected last. Words that follow as payload are never treated as headers. Register 1 is the frame address, register 2 is frame data and register 4 is the command register.
- R3: With enable set, each frame-address payload word is rewritten. The row field [20:16] gets the signed row offset added, modulo 32. The major field [15:8] gets the signed major offset added, modulo 256. The block type [22:21], the minor field [7:0] and bits [31:24] are kept. All header words are forwarded unchanged.
- R4: With enable set and flip clear, frame data and all non-address words pass unchanged at one word per clock with no stall.
- R5: With enable and flip set, the top/bottom bit [23] of each frame-address payload word is inverted.
- R6: With enable and flip set, frame-data payload is taken in frames of FRAME_WORDS words (odd). Output word j of a frame is the bit-reversed input word FRAME_WORDS-1-j, except that the middle word j=FRAME_WORDS/2 is output unchanged. The input is stalled while a frame is emitted.
- R7: A command-register payload whose low five bits equal 2 (multiple-frame write) is replaced by an all-zero word when enable and flip are set, and err is raised. Without flip it is forwarded unchanged.
- R8: With enable set, err is raised when a translated row falls outside 0..NUM_ROWS-1 or a translated major falls outside 0..NUM_MAJORS-1 (the word is still forwarded). err stays set until reset.
- R9: A cfg_load pulse is ignored while a register payload is pending or the mirror holds data. When the block is idle, a pulse takes effect for the next word.
- R10: After reset m_valid and err are low, s_ready follows m_ready, and relocation is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load pulse for the relocation settings |
| cfg_enable | input | 1 | Relocation enable |
| cfg_flip | input | 1 | Target is on the opposite half |
| cfg_row_off | input | 6 | Signed row offset |
| cfg_maj_off | input | 9 | Signed major-column offset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted |
| s_data | input | 32 | Input configuration word |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output port can take a word |
| m_data | output | 32 | Output configuration word |
| err | output | 1 | Sticky unsupported/out-of-range flag |

## Verification
Two functions can fall in the same cycle. Address translation with its range check can coincide with a load attempt, and a mirrored frame drain can coincide with backpressure on the output. The bench pulses cfg_load while a frame-data payload is still pending. It then checks that the next frame-address word is moved by the old offset and that an idle reload moves it by the new one. Mirrored frames are also drained under a pseudo-random m_ready pattern. The full output word sequence is compared against a model in the bench that reverses and offsets arithmetically.

// File: rtl/cfgreloc_pkg.sv
`timescale 1ns/1ps
package cfgreloc_pkg;
    localparam int WORD_W = 32;

    localparam logic [2:0] HDR_TYPE1 = 3'b001;
    localparam logic [2:0] HDR_TYPE2 = 3'b010;
    localparam logic [1:0] OP_WRITE  = 2'b10;

    localparam logic [4:0] REG_FADDR = 5'd1;
    localparam logic [4:0] REG_FDATA = 5'd2;
    localparam logic [4:0] REG_CTRL  = 5'd4;
    localparam logic [4:0] CTRL_MULTIWRITE = 5'd2;

    localparam int HALF_BIT = 23;
    localparam int ROW_LSB  = 16;
    localparam int ROW_W    = 5;
    localparam int MAJ_LSB  = 8;
    localparam int MAJ_W    = 8;
    localparam int CNT_W    = 27;

    typedef struct packed {
        logic                    en;
        logic                    flip;
        logic signed [ROW_W:0]   row_off;
        logic signed [MAJ_W:0]   maj_off;
    } reloc_cfg_t;

    typedef enum logic [2:0] {
        WK_HEADER,
        WK_FADDR,
        WK_FDATA,
        WK_CTRL,
        WK_OTHER
    } word_kind_t;

    typedef struct packed {
        logic [2:0]       htype;
        logic [1:0]       op;
        logic [4:0]       regsel;
        logic [CNT_W-1:0] count;
    } hdr_t;

    function automatic hdr_t decode_header(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.htype  = w[31:29];
        h.op     = w[28:27];
        h.regsel = w[17:13];
        h.count  = (w[31:29] == HDR_TYPE1) ? {16'b0, w[10:0]} : w[26:0];
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] bit_reverse(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) begin
            r[i] = w[WORD_W-1-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/cfgreloc_parser.sv
`timescale 1ns/1ps
module cfgreloc_parser
    import cfgreloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [WORD_W-1:0] word,
    output word_kind_t        kind,
    output logic              busy
);
    logic [4:0]       reg_q;
    logic [CNT_W-1:0] left_q;
    hdr_t             hdr;

    assign hdr  = decode_header(word);
    assign busy = (left_q != '0);

    always_comb begin
        if (left_q == '0) begin
            kind = WK_HEADER;
        end else begin
            case (reg_q)
                REG_FADDR: kind = WK_FADDR;
                REG_FDATA: kind = WK_FDATA;
                REG_CTRL:  kind = WK_CTRL;
                default:   kind = WK_OTHER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q  <= '0;
            left_q <= '0;
        end else if (adv) begin
            if (left_q == '0) begin
                if (hdr.htype == HDR_TYPE1) begin
                    reg_q  <= hdr.regsel;
                    left_q <= (hdr.op == OP_WRITE) ? hdr.count : '0;
                end else if (hdr.htype == HDR_TYPE2) begin
                    left_q <= (hdr.op == OP_WRITE) ? hdr.count : '0;
                end
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgreloc_far_xlate.sv
`timescale 1ns/1ps
module cfgreloc_far_xlate
    import cfgreloc_pkg::*;
#(
    parameter int NUM_ROWS   = 4,
    parameter int NUM_MAJORS = 24
) (
    input  logic [WORD_W-1:0] word,
    input  reloc_cfg_t        cfg,
    output logic [WORD_W-1:0] xlated,
    output logic              out_of_range
);
    localparam logic signed [ROW_W+1:0] ROW_LIM = (ROW_W+2)'(NUM_ROWS);
    localparam logic signed [MAJ_W+1:0] MAJ_LIM = (MAJ_W+2)'(NUM_MAJORS);

    logic signed [ROW_W+1:0] row_sum;
    logic signed [MAJ_W+1:0] maj_sum;

    always_comb begin
        row_sum = $signed({2'b00, word[ROW_LSB +: ROW_W]})
                + $signed({cfg.row_off[ROW_W], cfg.row_off});
        maj_sum = $signed({2'b00, word[MAJ_LSB +: MAJ_W]})
                + $signed({cfg.maj_off[MAJ_W], cfg.maj_off});

        out_of_range = row_sum[ROW_W+1] || (row_sum >= ROW_LIM)
                    || maj_sum[MAJ_W+1] || (maj_sum >= MAJ_LIM);

        xlated                     = word;
        xlated[ROW_LSB +: ROW_W]   = row_sum[ROW_W-1:0];
        xlated[MAJ_LSB +: MAJ_W]   = maj_sum[MAJ_W-1:0];
        xlated[HALF_BIT]           = word[HALF_BIT] ^ cfg.flip;
    end
endmodule

// File: rtl/cfgreloc_mirror.sv
`timescale 1ns/1ps
module cfgreloc_mirror
    import cfgreloc_pkg::*;
#(
    parameter int FRAME_WORDS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              busy
);
    localparam int IDX_W = $clog2(FRAME_WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_WORDS - 1);
    localparam logic [IDX_W-1:0] MID  = IDX_W'(FRAME_WORDS / 2);

    logic [WORD_W-1:0] fbuf_q [FRAME_WORDS];
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  src_idx;
    logic              drain_q;

    assign in_ready  = !drain_q;
    assign out_valid = drain_q;
    assign busy      = drain_q || (idx_q != '0);
    assign src_idx   = LAST - idx_q;
    assign out_data  = (idx_q == MID) ? fbuf_q[MID] : bit_reverse(fbuf_q[src_idx]);

    always_ff @(posedge clk) begin
        if (in_valid && !drain_q) begin
            fbuf_q[idx_q] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            drain_q <= 1'b0;
        end else if (!drain_q) begin
            if (in_valid) begin
                if (idx_q == LAST) begin
                    idx_q   <= '0;
                    drain_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end else if (out_ready) begin
            if (idx_q == LAST) begin
                idx_q   <= '0;
                drain_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgreloc_filter.sv
`timescale 1ns/1ps
module cfgreloc_filter
    import cfgreloc_pkg::*;
#(
    parameter int FRAME_WORDS = 5,
    parameter int NUM_ROWS    = 4,
    parameter int NUM_MAJORS  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              cfg_enable,
    input  logic              cfg_flip,
    input  logic [ROW_W:0]    cfg_row_off,
    input  logic [MAJ_W:0]    cfg_maj_off,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              err
);
    reloc_cfg_t        cfg_q;
    word_kind_t        kind;
    logic              parse_busy;
    logic              mir_busy;
    logic              busy;
    logic              accept;
    logic [WORD_W-1:0] far_word;
    logic              far_bad;
    logic [WORD_W-1:0] xform;
    logic              block_multi;
    logic              to_mirror;
    logic              mir_in_valid;
    logic              mir_in_ready;
    logic              mir_out_valid;
    logic              mir_out_ready;
    logic [WORD_W-1:0] mir_out_data;

    assign busy = parse_busy || mir_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_load && !busy) begin
            cfg_q.en      <= cfg_enable;
            cfg_q.flip    <= cfg_flip;
            cfg_q.row_off <= $signed(cfg_row_off);
            cfg_q.maj_off <= $signed(cfg_maj_off);
        end
    end

    cfgreloc_parser u_parse (
        .clk  (clk),
        .rst  (rst),
        .adv  (accept),
        .word (s_data),
        .kind (kind),
        .busy (parse_busy)
    );

    cfgreloc_far_xlate #(
        .NUM_ROWS   (NUM_ROWS),
        .NUM_MAJORS (NUM_MAJORS)
    ) u_far (
        .word         (s_data),
        .cfg          (cfg_q),
        .xlated       (far_word),
        .out_of_range (far_bad)
    );

    cfgreloc_mirror #(
        .FRAME_WORDS (FRAME_WORDS)
    ) u_mirror (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (mir_in_valid),
        .in_data   (s_data),
        .in_ready  (mir_in_ready),
        .out_valid (mir_out_valid),
        .out_data  (mir_out_data),
        .out_ready (mir_out_ready),
        .busy      (mir_busy)
    );

    assign to_mirror   = cfg_q.en && cfg_q.flip && (kind == WK_FDATA);
    assign block_multi = cfg_q.en && cfg_q.flip && (kind == WK_CTRL)
                      && (s_data[4:0] == CTRL_MULTIWRITE);

    always_comb begin
        if (cfg_q.en && kind == WK_FADDR) begin
            xform = far_word;
        end else if (block_multi) begin
            xform = '0;
        end else begin
            xform = s_data;
        end
    end

    always_comb begin
        mir_in_valid  = 1'b0;
        mir_out_ready = 1'b0;
        if (mir_out_valid) begin
            m_valid       = 1'b1;
            m_data        = mir_out_data;
            s_ready       = 1'b0;
            mir_out_ready = m_ready;
        end else if (to_mirror) begin
            m_valid      = 1'b0;
            m_data       = '0;
            s_ready      = mir_in_ready;
            mir_in_valid = s_valid;
        end else begin
            m_valid = s_valid;
            m_data  = xform;
            s_ready = m_ready;
        end
    end

    assign accept = s_valid && s_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (accept && ((cfg_q.en && kind == WK_FADDR && far_bad) || block_multi)) begin
            err <= 1'b1;
        end
    end
endmodule

// File: rtl/cfgreloc_checker.sv
`timescale 1ns/1ps
module cfgreloc_checker
    import cfgreloc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              s_valid,
    input logic              s_ready,
    input logic [WORD_W-1:0] s_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic [WORD_W-1:0] m_data,
    input logic              err,
    input reloc_cfg_t        cfg_q,
    input logic              busy
);
    // R8: error flag holds once raised
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9: settings do not move while a payload or frame is in flight
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    // R1: disabled filter is transparent
    a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && s_valid) |-> (m_valid && m_data == s_data));

    // R4: same-half relocation never stalls the stream
    a_r4_no_stall: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && !cfg_q.flip) |-> (s_ready == m_ready && m_valid == s_valid));

    // R10: reset clears the error flag
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> !err);
endmodule

bind cfgreloc_filter cfgreloc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .err     (err),
    .cfg_q   (cfg_q),
    .busy    (busy)
);

// File: tb/cfgreloc_filter_tb_top.sv
`timescale 1ns/1ps
module cfgreloc_filter_tb_top;
    localparam int FW = 5;
    localparam int NR = 4;
    localparam int NM = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_flip = 1'b0;
    logic [5:0]  cfg_row_off = '0;
    logic [8:0]  cfg_maj_off = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_data;
    logic        err;

    int n_vec = 0;
    int n_bad = 0;
    int stalls = 0;
    bit finished = 0;
    bit bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    bit m_en = 0;
    bit m_flip = 0;
    int m_ro = 0;
    int m_mo = 0;
    bit exp_err = 0;

    logic [31:0] stim_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];

    always #2.5 clk = ~clk;

    cfgreloc_filter #(.FRAME_WORDS(FW), .NUM_ROWS(NR), .NUM_MAJORS(NM)) dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
        .cfg_flip(cfg_flip), .cfg_row_off(cfg_row_off), .cfg_maj_off(cfg_maj_off),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .err(err)
    );

    always @(posedge clk) begin
        #1;
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_ready <= bp_mode ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst && m_valid && m_ready) got_q.push_back(m_data);
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rev32(input logic [31:0] w);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = w[i];
        return r;
    endfunction

    function automatic logic [31:0] hdr1(input logic [4:0] regsel, input int cnt);
        return {3'b001, 2'b10, 9'd0, regsel, 2'b00, 11'(cnt)};
    endfunction

    function automatic logic [31:0] hdr2(input int cnt);
        return {3'b010, 2'b10, 27'(cnt)};
    endfunction

    task automatic push(input logic [31:0] st, input logic [31:0] ex);
        stim_q.push_back(st);
        exp_q.push_back(ex);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        s_valid = 1'b0;
        cfg_load = 1'b0;
        bp_mode = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        stim_q.delete(); exp_q.delete(); got_q.delete();
        m_en = 0; m_flip = 0; m_ro = 0; m_mo = 0; exp_err = 0;
        @(posedge clk); #1;
    endtask

    task automatic pulse_load(input bit en, input bit fl, input int ro, input int mo);
        cfg_enable = en; cfg_flip = fl;
        cfg_row_off = 6'(ro); cfg_maj_off = 9'(mo);
        cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    task automatic load_cfg(input bit en, input bit fl, input int ro, input int mo);
        pulse_load(en, fl, ro, mo);
        m_en = en; m_flip = fl; m_ro = ro; m_mo = mo;
    endtask

    task automatic add_far(input bit half, input int typ, input int row, input int maj, input int minr);
        logic [31:0] w, e;
        int r, m;
        w = {8'h00, half, 2'(typ), 5'(row), 8'(maj), 8'(minr)};
        e = w;
        if (m_en) begin
            r = row + m_ro;
            m = maj + m_mo;
            if (r < 0 || r >= NR || m < 0 || m >= NM) exp_err = 1;
            e[20:16] = 5'(r);
            e[15:8]  = 8'(m);
            e[23]    = half ^ m_flip;
        end
        push(hdr1(5'd1, 1), hdr1(5'd1, 1));
        push(w, e);
    endtask

    task automatic add_frames(input int nfr, input int seed, input bit use_t2);
        logic [31:0] fr [FW];
        if (use_t2) begin
            push(hdr1(5'd2, 0), hdr1(5'd2, 0));
            push(hdr2(nfr*FW), hdr2(nfr*FW));
        end else begin
            push(hdr1(5'd2, nfr*FW), hdr1(5'd2, nfr*FW));
        end
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < FW; k++) begin
                fr[k] = 32'((f*FW + k + 1) * 32'h9E3779B1) ^ 32'(seed);
                stim_q.push_back(fr[k]);
            end
            for (int j = 0; j < FW; j++) begin
                if (m_en && m_flip)
                    exp_q.push_back((j == FW/2) ? fr[j] : rev32(fr[FW-1-j]));
                else
                    exp_q.push_back(fr[j]);
            end
        end
    endtask

    task automatic add_ctrl(input logic [31:0] val);
        push(hdr1(5'd4, 1), hdr1(5'd4, 1));
        if (m_en && m_flip && val[4:0] == 5'd2) begin
            push(val, 32'h0);
            exp_err = 1;
        end else begin
            push(val, val);
        end
    endtask

    task automatic send_all();
        stalls = 0;
        for (int i = 0; i < stim_q.size(); i++) begin
            s_valid = 1'b1;
            s_data  = stim_q[i];
            @(negedge clk);
            while (!s_ready) begin
                stalls++;
                @(negedge clk);
            end
            @(posedge clk); #1;
        end
        s_valid = 1'b0;
    endtask

    task automatic run_stream(input string tag, input bit no_stall);
        send_all();
        for (int t = 0; t < 200 && got_q.size() < exp_q.size(); t++) @(posedge clk);
        #1;
        check(got_q.size() == exp_q.size(), {tag, " word count"}, 32'(got_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] === exp_q[i], tag, got_q[i], exp_q[i]);
        if (no_stall) check(stalls == 0, {tag, " R4 stall count"}, 32'(stalls), 32'd0);
        check(err === exp_err, {tag, " R8 err flag"}, {31'd0, err}, {31'd0, exp_err});
        stim_q.delete(); exp_q.delete(); got_q.delete();
    endtask

    task automatic std_mix(input int seed);
        push(32'hAA995566, 32'hAA995566);
        push(32'h20000000, 32'h20000000);
        for (int row = 0; row < NR; row++) begin
            add_far(1'(row), row % 3, row, 0, row);
            add_far(1'(row + 1), 1, row, 7, 3*row + 1);
            add_far(1'b0, 2, row, NM-1, 21);
        end
        add_frames(2, seed, 0);
        add_ctrl(32'h7);
        add_far(1'b1, 0, 1, 3, 9);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: idle after reset
        check(m_valid === 1'b0, "R10 m_valid after reset", {31'd0, m_valid}, 32'd0);
        check(err === 1'b0, "R10 err after reset", {31'd0, err}, 32'd0);
        check(s_ready === 1'b1, "R10 s_ready follows m_ready", {31'd0, s_ready}, 32'd1);

        // R10/R1: default disabled, then disabled with flip and offsets set
        std_mix(32'h11);
        add_ctrl(32'h2);
        run_stream("R10 R1 default transparent", 1);
        pulse_load(1'b0, 1'b1, 3, -5);
        std_mix(32'h22);
        add_ctrl(32'h2);
        run_stream("R1 disabled with flip", 1);

        // R3 R4 R5 R6 R8: sweep of offsets and halves
        for (int fl = 0; fl < 2; fl++) begin
            for (int ri = 0; ri < 4; ri++) begin
                for (int mi = 0; mi < 3; mi++) begin
                    int ro_t[4] = '{-1, 0, 1, 3};
                    int mo_t[3] = '{-2, 0, 2};
                    do_reset();
                    load_cfg(1'b1, 1'(fl), ro_t[ri], mo_t[mi]);
                    std_mix(fl*100 + ri*10 + mi);
                    run_stream(fl ? "R3 R5 R6 R8 flip sweep" : "R3 R4 R8 same-half sweep", fl == 0);
                end
            end
        end

        // R2 R6: type-2 counts with backpressure on mirrored frames
        do_reset();
        load_cfg(1'b1, 1'b1, 0, 0);
        bp_mode = 1;
        add_frames(3, 32'h5A5A, 1);
        add_far(1'b0, 0, 2, 4, 6);
        push(32'h2800_0003, 32'h2800_0003);
        add_frames(1, 32'h77, 0);
        run_stream("R2 R6 type-2 and backpressure", 0);
        bp_mode = 0;

        // R7: multiple-frame write blocked across halves
        do_reset();
        load_cfg(1'b1, 1'b1, 0, 0);
        add_ctrl(32'h2);
        run_stream("R7 multiwrite blocked", 0);
        do_reset();
        load_cfg(1'b1, 1'b0, 0, 0);
        add_ctrl(32'h2);
        add_ctrl(32'h22);
        run_stream("R7 multiwrite same half", 1);

        // R9: load attempt during a pending payload is ignored
        do_reset();
        load_cfg(1'b1, 1'b0, 1, 0);
        add_frames(2, 32'h99, 0);
        add_far(1'b0, 0, 0, 2, 0);
        fork
            run_stream("R9 load ignored while busy", 1);
            begin
                repeat (4) @(posedge clk);
                #1;
                pulse_load(1'b1, 1'b0, 2, 0);
            end
        join
        load_cfg(1'b1, 1'b0, 2, 0);
        add_far(1'b0, 0, 0, 2, 0);
        run_stream("R9 load taken when idle", 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule